// File: doc/BRIEF.md
# Pseudo-Random Test-Word Link Checker

This block checks the link from a 16-bit converter. The converter sends known pseudo-random test words, and the block compares each one with a sequence it generates itself. Software runs the check before any capture starts, and capture goes ahead only when the check finds no errors. A single select input chooses one of two generators. The short generator uses the recurrence x^9+x^5+1. The long generator uses x^23+x^18+1. Each received word carries 16 consecutive bits of the sequence. The generated sequence is used unchanged, except that the top bit of every word is inverted. Because of this, the block does not accept sequences that follow the usual telecom test-pattern convention.

The checker starts unlocked. While unlocked, it takes its history from the words it receives and predicts each next word from that history. After four correct predictions in a row it declares lock. From then on it runs freely: every mismatching word is counted in a saturating error counter and sets a sticky error flag. If eight words in a row mismatch, the checker drops lock and seeds itself again. A clear pulse, or any change of the select input, returns the checker to its starting state.

Top module: `pn_link_checker`

## Requirements
- R1: With mode_i=0, the expected word comes from the bit recurrence b[n]=b[n-9]^b[n-5]. The oldest of its 16 new bits sits at bit 15. A received word matches only if bit 15 is the inverse of the sequence bit and bits 14:0 equal the sequence bits. A word with no bit inverted, or with all bits inverted, is a mismatch.
- R2: While unlocked, each accepted word is shifted into the history, whether or not it matches. locked_o rises on the clock edge that accepts the fourth correct prediction in a row. Any mismatch restarts that run.
- R3: With mode_i=1, the recurrence is b[n]=b[n-23]^b[n-18]. Lock follows the same rule as in R2.
- R4: While locked, each accepted mismatching word raises err_cnt_o by exactly one and sets err_o, which then stays high. Matching words leave both unchanged. While unlocked, mismatches are not counted.
- R5: While locked, the history advances by its own prediction. The eighth mismatch in a row clears locked_o on that word's edge and loads the history from that word. Any match resets the run of mismatches.
- R6: On the edge where clr_i is high, or where mode_i differs from its value at the previous edge, locked_o, err_o and err_cnt_o go to 0. The history is zeroed and the word in that cycle is discarded.
- R7: err_cnt_o saturates at its all-ones value and holds there.
- R8: A word is accepted only when valid_i and en_i are both high. Otherwise no output and no state changes.
- R9: While rst_ni is low, locked_o, err_o and err_cnt_o are 0 and the mode is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Received test word |
| valid_i | input | 1 | data_i holds a word this cycle |
| en_i | input | 1 | Checker enable |
| mode_i | input | 1 | 0 selects the 9-stage sequence, 1 selects the 23-stage sequence |
| clr_i | input | 1 | Synchronous restart |
| locked_o | output | 1 | Checker is in lock |
| err_o | output | 1 | Sticky mismatch flag |
| err_cnt_o | output | ERR_W | Saturating count of mismatching words |

## Verification
Every result is registered, so the effect of a word presented before edge k appears on all three outputs just after edge k. This includes lock rising on the fourth match, lock falling on the eighth miss, and the restart caused by clear or a mode change. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge. It compares all outputs at the following falling edge, which means every check falls exactly one edge after its stimulus. The bench instantiates a 6-bit error counter so that saturation can be reached quickly.

// File: rtl/pn_chk_pkg.sv
package pn_chk_pkg;
  typedef enum logic {PN_SHORT = 1'b0, PN_LONG = 1'b1} pn_mode_e;
  // taps as distances-1 into history (bit 0 newest)
  localparam int unsigned SHORT_A = 8;
  localparam int unsigned SHORT_B = 4;
  localparam int unsigned LONG_A  = 22;
  localparam int unsigned LONG_B  = 17;
endpackage

// File: rtl/pn_predict.sv
module pn_predict
  import pn_chk_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HIST_W = 32
) (
  input  logic [HIST_W-1:0] hist_i,
  input  pn_mode_e          mode_i,
  output logic [DATA_W-1:0] pred_o
);
  logic [HIST_W-1:0] tmp;
  logic              nb;

  always_comb begin
    tmp    = hist_i;
    nb     = 1'b0;
    pred_o = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (mode_i == PN_LONG) nb = tmp[LONG_A] ^ tmp[LONG_B];
      else                   nb = tmp[SHORT_A] ^ tmp[SHORT_B];
      pred_o[DATA_W-1-i] = nb;
      tmp = {tmp[HIST_W-2:0], nb};
    end
  end
endmodule

// File: rtl/pn_sync.sv
module pn_sync #(
  parameter int unsigned LOCK_RUN = 4,
  parameter int unsigned LOSS_RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fire_i,
  input  logic hit_i,
  output logic locked_o,
  output logic seed_o,
  output logic miss_o
);
  localparam int unsigned RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int unsigned MISS_W = $clog2(LOSS_RUN + 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(LOCK_RUN - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_RUN - 1);

  logic              locked_q;
  logic [RUN_W-1:0]  run_q;
  logic [MISS_W-1:0] miss_q;
  logic              drop;

  assign drop     = fire_i && locked_q && !hit_i && (miss_q == MISS_LAST);
  assign seed_o   = fire_i && (!locked_q || drop);
  assign miss_o   = fire_i && locked_q && !hit_i;
  assign locked_o = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      run_q    <= '0;
      miss_q   <= '0;
    end else if (clr_i) begin
      locked_q <= 1'b0;
      run_q    <= '0;
      miss_q   <= '0;
    end else if (fire_i) begin
      if (!locked_q) begin
        if (!hit_i)                run_q <= '0;
        else if (run_q == RUN_LAST) begin
          locked_q <= 1'b1;
          run_q    <= '0;
        end else                   run_q <= run_q + 1'b1;
      end else if (hit_i) begin
        miss_q <= '0;
      end else if (drop) begin
        locked_q <= 1'b0;
        miss_q   <= '0;
      end else begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end

  p_clr_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !locked_o);
  p_lock_on_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(fire_i && hit_i));
  p_unlock_on_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(locked_o) && !$past(clr_i)) |-> $past(fire_i && !hit_i));
endmodule

// File: rtl/pn_err_count.sv
module pn_err_count #(
  parameter int unsigned ERR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [ERR_W-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      err_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      err_o <= 1'b0;
    end else if (inc_i) begin
      err_o <= 1'b1;
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);
  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/pn_link_checker.sv
module pn_link_checker
  import pn_chk_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ERR_W    = 16,
  parameter int unsigned LOCK_RUN = 4,
  parameter int unsigned LOSS_RUN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              en_i,
  input  logic              mode_i,
  input  logic              clr_i,
  output logic              locked_o,
  output logic              err_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int unsigned HIST_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  pn_mode_e          mode_q;
  logic              restart;
  logic              fire;
  logic [DATA_W-1:0] rx_raw;
  logic [DATA_W-1:0] pred;
  logic              hit;
  logic              seed;
  logic              miss;
  logic [HIST_W-1:0] hist_q;

  assign restart = clr_i || (pn_mode_e'(mode_i) != mode_q);
  assign fire    = valid_i && en_i && !restart;
  assign rx_raw  = data_i ^ MSB_MASK;
  assign hit     = (rx_raw == pred);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= PN_SHORT;
    else         mode_q <= pn_mode_e'(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (restart) hist_q <= '0;
    else if (fire)    hist_q <= {hist_q[HIST_W-DATA_W-1:0], seed ? rx_raw : pred};
  end

  pn_predict #(.DATA_W(DATA_W), .HIST_W(HIST_W)) u_pred (
    .hist_i (hist_q),
    .mode_i (mode_q),
    .pred_o (pred)
  );

  pn_sync #(.LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart),
    .fire_i   (fire),
    .hit_i    (hit),
    .locked_o (locked_o),
    .seed_o   (seed),
    .miss_o   (miss)
  );

  pn_err_count #(.ERR_W(ERR_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .inc_i  (miss),
    .cnt_o  (err_cnt_o),
    .err_o  (err_o)
  );

  p_count_needs_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o != $past(err_cnt_o) && !$past(restart)) |-> $past(locked_o));
  p_mode_change_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pn_mode_e'(mode_i) != mode_q) |=> (err_cnt_o == '0 && !locked_o && !err_o));
  p_idle_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(valid_i && en_i) && !restart) |=> ($stable(err_cnt_o) && $stable(locked_o)));
endmodule

// File: tb/sim_pn_link_checker.sv
`timescale 1ns/1ps
module sim_pn_link_checker;
  localparam int ERR_W = 6;
  logic clk_i = 0, rst_ni = 0;
  logic [15:0] data_i = '0;
  logic valid_i = 0, en_i = 0, mode_i = 0, clr_i = 0;
  logic locked_o, err_o;
  logic [ERR_W-1:0] err_cnt_o;

  int tests = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  pn_link_checker #(.DATA_W(16), .ERR_W(ERR_W)) u0 (
    .clk_i, .rst_ni, .data_i, .valid_i, .en_i, .mode_i, .clr_i,
    .locked_o, .err_o, .err_cnt_o
  );

  // behavioural model
  bit mh[$];
  bit sq[$];
  bit m_lock, m_err, m_mode_prev;
  int m_run, m_miss, m_cnt;
  localparam int CMAX = (1 << ERR_W) - 1;

  function automatic logic [15:0] seq_next(ref bit q[$], input bit m);
    logic [15:0] w;
    bit nb;
    for (int i = 0; i < 16; i++) begin
      nb = m ? (q[q.size()-23] ^ q[q.size()-18]) : (q[q.size()-9] ^ q[q.size()-5]);
      q.push_back(nb);
      w[15-i] = nb;
    end
    while (q.size() > 32) void'(q.pop_front());
    return w;
  endfunction

  function automatic logic [15:0] model_pred(bit m);
    bit q[$];
    q = mh;
    return seq_next(q, m);
  endfunction

  function automatic void mh_push(logic [15:0] w);
    for (int i = 15; i >= 0; i--) mh.push_back(w[i]);
    while (mh.size() > 32) void'(mh.pop_front());
  endfunction

  function automatic void mh_zero();
    mh.delete();
    for (int i = 0; i < 32; i++) mh.push_back(1'b0);
  endfunction

  function automatic void model_step();
    logic [15:0] rx, p;
    bit chg;
    chg = clr_i || (mode_i != m_mode_prev);
    m_mode_prev = mode_i;
    if (chg) begin
      m_lock = 0; m_err = 0; m_cnt = 0; m_run = 0; m_miss = 0;
      mh_zero();
    end else if (valid_i && en_i) begin
      rx = data_i ^ 16'h8000;
      p  = model_pred(mode_i);
      if (!m_lock) begin
        mh_push(rx);
        if (rx == p) begin
          if (m_run == 3) begin m_lock = 1; m_run = 0; end
          else m_run++;
        end else m_run = 0;
      end else if (rx == p) begin
        m_miss = 0;
        mh_push(p);
      end else begin
        m_err = 1;
        if (m_cnt < CMAX) m_cnt++;
        if (m_miss == 7) begin m_lock = 0; m_miss = 0; mh_push(rx); end
        else begin m_miss++; mh_push(p); end
      end
    end
  endfunction

  task automatic check(string tag);
    tests++;
    if (locked_o !== m_lock || err_o !== m_err || int'(err_cnt_o) != m_cnt) begin
      fails++;
      $display("FAIL %s: lock/err/cnt actual %b/%b/%0d expected %b/%b/%0d",
               tag, locked_o, err_o, err_cnt_o, m_lock, m_err, m_cnt);
    end
  endtask

  task automatic step(logic [15:0] d, logic v, logic e, logic m, logic c, string tag);
    data_i = d; valid_i = v; en_i = e; mode_i = m; clr_i = c;
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    check(tag);
  endtask

  function automatic logic [15:0] good(bit m);
    return seq_next(sq, m) ^ 16'h8000;
  endfunction

  task automatic expect_bit(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(10 * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [32:0] s;
    s = 33'h0ACE12357;
    for (int i = 0; i < 32; i++) sq.push_back(s[i]);
    mh_zero();
    m_mode_prev = 0;
    repeat (3) @(negedge clk_i);
    check("R9 reset");
    rst_ni = 1;
    @(negedge clk_i);
    check("R9 after release");

    // R1/R2: short sequence lock
    for (int i = 0; i < 5; i++) step(good(0), 1, 1, 0, 0, "R2 acquire");
    expect_bit("R2 locked after fourth match", locked_o, 1'b1);
    for (int i = 0; i < 6; i++) step(good(0), 1, 1, 0, 0, "R1 tracking");
    expect_bit("R1 no error on good stream", err_o, 1'b0);
    // R1: raw (no MSB inversion) and full inversion both mismatch
    step(good(0) ^ 16'h8000, 1, 1, 0, 0, "R1 msb not inverted");
    step(good(0) ^ 16'hFFFF, 1, 1, 0, 0, "R1 all bits inverted");
    step(good(0), 1, 1, 0, 0, "R4 match after misses");
    // R8: garbage ignored when not accepted
    step(16'h1234, 1, 0, 0, 0, "R8 enable low");
    step(16'h4321, 0, 1, 0, 0, "R8 valid low");
    step(16'hFFFF, 0, 0, 0, 0, "R8 both low");
    step(good(0), 1, 1, 0, 0, "R8 stream resumes");
    // R5: eight misses drop lock
    for (int i = 0; i < 8; i++) step(good(0) ^ 16'h0101, 1, 1, 0, 0, "R5 miss run");
    expect_bit("R5 lock dropped", locked_o, 1'b0);
    for (int i = 0; i < 7; i++) step(good(0), 1, 1, 0, 0, "R5 reacquire");
    expect_bit("R5 relocked", locked_o, 1'b1);
    // R6: clear
    step(good(0), 1, 1, 0, 1, "R6 clear");
    expect_bit("R6 clear unlocks", locked_o, 1'b0);
    // R3/R6: mode change to long sequence
    for (int i = 0; i < 3; i++) void'(good(1));
    step(good(1), 1, 1, 1, 0, "R6 mode change");
    for (int i = 0; i < 7; i++) step(good(1), 1, 1, 1, 0, "R3 acquire");
    expect_bit("R3 long locked", locked_o, 1'b1);
    // R7: saturation
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 7; i++) step(good(1) ^ 16'h0010, 1, 1, 1, 0, "R7 misses");
      step(good(1), 1, 1, 1, 0, "R7 keep lock");
    end
    expect_bit("R7 saturated", err_cnt_o == '1, 1'b1);
    step(good(1) ^ 16'h0002, 1, 1, 1, 0, "R7 hold at max");
    // R6: back to short mode clears
    step(16'h0000, 1, 1, 0, 0, "R6 mode back");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule